// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block turns a set of reset causes into one clean, stretched reset that appears on two complementary reset pads. The causes are a digital supply-good flag, a one-cycle watchdog-expired pulse, and edges seen on the two reset pads. External logic may drive either pad, so the block also cleans up short external reset pulses. Every reset event is held for a fixed number of ticks of a slow oscillator enable. If an external source keeps a pad asserted beyond that window, the reset lasts until that source lets go. A busy flag tells the watchdog that a reset is in progress, so the watchdog can keep itself cleared.

Both pads are open-drain style. The block only outputs drive enables: one pulls the active-low pad low and the other pushes the active-high pad high. Each sensed pad level passes through a synchronizer. After the block releases its own drive, it waits out a settle window so that its own release is never taken for an external event.

The controller is a five-state machine:
- OFF: the supply is below trip and both pads are driven.
- STRETCH: both pads are driven while the tick timer runs.
- SETTLE: the drive is released and the synchronizers refill.
- HOLD: an external source still asserts a pad and the drive is released.
- IDLE: waiting for a reset cause.

The transitions are:
- Any state goes to OFF when the supply is lost.
- OFF goes to STRETCH when the supply returns (power-up).
- STRETCH goes to SETTLE when the tick timer is done.
- SETTLE goes to HOLD if a pad is still asserted after the window, and to IDLE otherwise.
- HOLD goes to IDLE when both pads read deasserted.
- IDLE goes to STRETCH on a watchdog pulse or on a pad edge.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: While reset is applied or `supply_ok` is low, `drv_rstn_low` and `drv_rst_high` are both 1 and `busy` is 1.
- R2: After `supply_ok` rises, both drives stay asserted for `TIMEOUT_TICKS` ticks of `tick_en` (from 1 to 1 tick period short of that window), then release.
- R3: When `supply_ok` falls, both drives are asserted on the next clock.
- R4: `drv_rstn_low` and `drv_rst_high` are always equal (complementary pads are asserted together).
- R5: In IDLE, a high-to-low edge on `pad_rstn` (active-low pad, 0 = asserted) starts a full `TIMEOUT_TICKS` stretch on both drives.
- R6: In IDLE, a low-to-high edge on `pad_rst` (active-high pad, 1 = asserted) starts a full `TIMEOUT_TICKS` stretch on both drives.
- R7: An external pad pulse lasting at least one clock and shorter than the timeout still gives a drive pulse covering at least `TIMEOUT_TICKS` ticks.
- R8: A one-cycle `wdog_expire` pulse in IDLE gives a full `TIMEOUT_TICKS` stretch on both drives, then both release.
- R9: If an external source holds a pad asserted past the timeout, the drives release at the timeout. `busy` then stays 1 while the pad stays asserted, and falls within SYNC_STAGES+4 clocks of the pad's release.
- R10: The release of the block's own drive triggers no new reset: with no external activity, `busy` returns to 0 and the drives stay 0.
- R11: `busy` is 1 whenever either drive is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable from the slow oscillator |
| supply_ok | input | 1 | Supply above trip level |
| wdog_expire | input | 1 | One-cycle watchdog timeout request |
| pad_rstn | input | 1 | Sensed level of the active-low reset pad |
| pad_rst | input | 1 | Sensed level of the active-high reset pad |
| drv_rstn_low | output | 1 | Enable to pull the active-low pad low |
| drv_rst_high | output | 1 | Enable to push the active-high pad high |
| busy | output | 1 | Reset in progress, for the watchdog |

## Verification
The bench builds the block with TIMEOUT_TICKS = 8 and a tick every fourth clock, so one stretch takes about 32 clocks. At that length, power-up, supply drop, watchdog and edge-started resets all fit in a short run, next to pad holds lasting tens of clocks past the timeout. The bench keeps SYNC_STAGES at 2, so the settle window after its own release lasts three clocks. Random pulse lengths around one clock and around the timeout land on both sides of the short-pulse and long-hold boundaries.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_STRETCH,
        ST_SETTLE,
        ST_HOLD,
        ST_IDLE
    } rpc_state_t;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else begin
                    if (s == 0) chain[s] <= d;
                    else        chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rpc_tick_timer.sv
module rpc_tick_timer #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/rpc_edge_det.sv
module rpc_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] asserted,
    input  logic             arm,
    output logic             hit,
    output logic             any_level
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= asserted;
    end

    assign hit       = arm && |(asserted & ~prev);
    assign any_level = |asserted;
endmodule

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl
    import rpc_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic supply_ok,
    input  logic wdog_expire,
    input  logic pad_rstn,
    input  logic pad_rst,
    output logic drv_rstn_low,
    output logic drv_rst_high,
    output logic busy
);
    localparam int SETTLE_CYC = SYNC_STAGES + 1;
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    rpc_state_t state, state_nx;

    logic [1:0] pads_s;
    logic [1:0] pads_asserted;
    logic       edge_hit;
    logic       pad_level;
    logic       timer_done;
    logic [SW-1:0] settle_cnt;

    // index 0: active-low pad, index 1: active-high pad
    rpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pad_rst, pad_rstn}),
        .q     (pads_s)
    );

    assign pads_asserted = {pads_s[1], ~pads_s[0]};

    rpc_edge_det #(.WIDTH(2)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .asserted  (pads_asserted),
        .arm       (state == ST_IDLE),
        .hit       (edge_hit),
        .any_level (pad_level)
    );

    rpc_tick_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_STRETCH),
        .tick  (tick_en),
        .done  (timer_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  settle_cnt <= '0;
        else if (state != ST_SETTLE) settle_cnt <= '0;
        else                         settle_cnt <= settle_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:     state_nx = ST_STRETCH;
            ST_STRETCH: if (timer_done) state_nx = ST_SETTLE;
            ST_SETTLE:  if (settle_cnt == SETTLE_LAST)
                            state_nx = pad_level ? ST_HOLD : ST_IDLE;
            ST_HOLD:    if (!pad_level) state_nx = ST_IDLE;
            ST_IDLE:    if (wdog_expire || edge_hit) state_nx = ST_STRETCH;
            default:    state_nx = ST_OFF;
        endcase
        if (!supply_ok) state_nx = ST_OFF;
    end

    always_comb begin
        drv_rstn_low = 1'b0;
        drv_rst_high = 1'b0;
        busy         = 1'b1;
        unique case (state)
            ST_OFF, ST_STRETCH: begin
                drv_rstn_low = 1'b1;
                drv_rst_high = 1'b1;
            end
            ST_SETTLE, ST_HOLD: ;
            ST_IDLE:    busy = 1'b0;
            default: begin
                drv_rstn_low = 1'b1;
                drv_rst_high = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
    parameter int TIMEOUT_TICKS = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic supply_ok,
    input logic drv_rstn_low,
    input logic drv_rst_high,
    input logic busy
);
    int ticks_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ticks_seen <= 0;
        else if (!drv_rstn_low)           ticks_seen <= 0;
        else if (tick_en && ticks_seen < TIMEOUT_TICKS)
                                          ticks_seen <= ticks_seen + 1;
    end

    assert_drop_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (drv_rstn_low && drv_rst_high));

    assert_powerup_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |=> drv_rstn_low);

    assert_busy_covers_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_rstn_low || drv_rst_high) |-> busy);

    assert_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_rstn_low) |-> (ticks_seen >= TIMEOUT_TICKS));
endmodule

bind rst_pulse_ctrl rpc_checker #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .supply_ok    (supply_ok),
    .drv_rstn_low (drv_rstn_low),
    .drv_rst_high (drv_rst_high),
    .busy         (busy)
);

// File: tb/tb_rst_pulse_ctrl.sv
`timescale 1ns/1ps
module tb_rst_pulse_ctrl;
    localparam int T = 8;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic supply_ok = 1'b0;
    logic wdog_expire = 1'b0;
    logic ext_low = 1'b0;
    logic ext_high = 1'b0;
    logic drv_rstn_low, drv_rst_high, busy;
    wire  pad_rstn = !(drv_rstn_low || ext_low);
    wire  pad_rst  = drv_rst_high || ext_high;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    rst_pulse_ctrl #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .supply_ok(supply_ok),
        .wdog_expire(wdog_expire), .pad_rstn(pad_rstn), .pad_rst(pad_rst),
        .drv_rstn_low(drv_rstn_low), .drv_rst_high(drv_rst_high), .busy(busy)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc = cyc + 1;
            tick_en = (cyc % D) == 0;
        end
    end

    function automatic int len_lo();
        return (T - 1) * D;
    endfunction

    function automatic int len_hi();
        return T * D + 2;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_window(input string tag);
        int bad = 0;
        for (int i = 0; i < 3 * D + 12; i++) begin
            step();
            if (busy || drv_rstn_low || drv_rst_high) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    // kind: 0 supply rise, 1 watchdog, 2 active-low pad, 3 active-high pad
    task automatic run_event(input int kind, input int dur, input string tag);
        int elapsed = 0;
        int rise = -1;
        int fall = -1;
        int mism = 0;
        int berr = 0;
        bit b_at = 1'b0;
        bit d_at = 1'b0;
        int len;
        case (kind)
            0: supply_ok = 1'b1;
            1: wdog_expire = 1'b1;
            2: ext_low = 1'b1;
            default: ext_high = 1'b1;
        endcase
        if (drv_rstn_low) rise = 0;
        while (!(fall >= 0 && elapsed >= dur) && elapsed < 2000) begin
            step();
            elapsed++;
            if (elapsed == dur) begin
                b_at = busy;
                d_at = drv_rstn_low;
                wdog_expire = 1'b0;
                ext_low = 1'b0;
                ext_high = 1'b0;
            end
            if (drv_rstn_low != drv_rst_high) mism++;
            if ((drv_rstn_low || drv_rst_high) && !busy) berr++;
            if (drv_rstn_low && rise < 0) rise = elapsed;
            if (!drv_rstn_low && rise >= 0 && fall < 0) fall = elapsed;
        end
        len = (rise >= 0 && fall >= 0) ? fall - rise : -1;
        check(len >= len_lo() && len <= len_hi(), {tag, " length"}, len, T * D);
        check(mism == 0, "R4 drives differ", mism, 0);
        check(berr == 0, "R11 busy low while driving", berr, 0);
        if (dur > len_hi() + 6) begin
            check(b_at == 1'b1 && d_at == 1'b0, "R9 hold busy/drive", {b_at, d_at}, 2);
        end
        for (int i = 0; i < 6; i++) step();
        check(busy == 1'b0, {tag, " busy after"}, busy, 0);
        idle_window("R10 self release");
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        #2;
        check(drv_rstn_low && drv_rst_high && busy, "R1 reset state",
              {drv_rstn_low, drv_rst_high, busy}, 7);
        repeat (4) step();
        rst_n = 1'b1;
        repeat (20) step();
        check(drv_rstn_low && drv_rst_high && busy, "R1 supply low",
              {drv_rstn_low, drv_rst_high, busy}, 7);

        run_event(0, 1, "R2 power-up");

        supply_ok = 1'b0;
        step();
        check(drv_rstn_low && drv_rst_high, "R3 supply drop",
              {drv_rstn_low, drv_rst_high}, 3);
        repeat (5) step();
        run_event(0, 1, "R2 power-up again");

        run_event(1, 1, "R8 watchdog");
        run_event(2, 1, "R5 R7 low pad short");
        run_event(3, 1, "R6 R7 high pad short");
        run_event(2, 5, "R5 low pad");
        run_event(3, 5, "R6 high pad");
        run_event(2, T * D + 25, "R9 low pad hold");
        run_event(3, T * D + 25, "R9 high pad hold");

        for (int n = 0; n < 24; n++) begin
            int k = int'($urandom_range(1, 3));
            int d;
            if (k == 1) d = 1;
            else if ($urandom_range(0, 1) == 0) d = int'($urandom_range(1, 2 * D));
            else d = T * D + 8 + int'($urandom_range(0, 30));
            run_event(k, d, (k == 1) ? "R8 random" : "R7 random pad");
            repeat (int'($urandom_range(0, 7))) step();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule